// File: doc/BRIEF.md
# Cascadable serial configuration store

This block is a bit-serial read-only store that feeds a preloaded bitstream to a device that is loading its configuration. The device being configured drives the clock. It keeps clocking for as many cycles as its configuration needs, because the store has no notion of a required length. While the store is selected and out of reset, the current bit is driven onto a shared data line. Each rising clock edge moves an internal bit address forward, and the next bit then appears on the line.

Several stores can form a chain to hold one long bitstream or several back to back. All stores share the clock and the data line. The cascade-out pin of each store drives the chip-enable of the next. A store that is not selected, or that has already sent its last bit, releases the data line to high impedance. The active level of the reset input is chosen at build time, and so is the depth of the store.

Top module: `scfg_store`

## Requirements
- R1: While reset is active, the bit address is zero, the cascade-out `ceo_n` is high (inactive), and `dat` is high impedance with `dat_oe` low. All of these take effect without waiting for a clock.
- R2: The store drives when `ce_n` is low, reset is inactive and its last bit has not been sent. In that state `dat` carries stored bit k (bit k of `INIT`, bit 0 first) after k such clock edges since reset, and each rising edge steps k by one.
- R3: While `ce_n` is high, `dat_oe` is low, `dat` is high impedance, and clock edges leave the address unchanged.
- R4: Clock edges that arrive while reset is active do not advance the address, even with `ce_n` low.
- R5: The clock edge that sends bit DEPTH-1 while the store is enabled drives `ceo_n` low. From then until reset, `ceo_n` stays low, `dat_oe` stays low, and further edges have no effect.
- R6: When `ceo_n` of one store drives `ce_n` of a second store on a shared clock, the bits seen on the shared data line at successive edges are the full first image followed by the full second image.
- R7: The parameter `RST_POL` selects the active level of `rst`. With `RST_ACT_HIGH`, `rst`=1 resets the store. With `RST_ACT_LOW`, `rst`=0 resets it.
- R8: If `ce_n` goes high partway through the image and later returns low, the stream resumes with the next unsent bit. No bit is lost and none is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the device being configured |
| ce_n | input | 1 | Chip enable, active low |
| rst | input | 1 | Reset and output-enable control, active level set by `RST_POL` |
| dat | output | 1 | Serial data; high impedance when not driving |
| dat_oe | output | 1 | High while the store drives `dat` |
| ceo_n | output | 1 | Cascade-out, active low, enables the next store |

## Verification
A chain of two stores is driven, with the first reset active high and the second active low, and both are compared against a behavioural model on every clock. The stimulus has four patterns. Reset is held with enable low, which shows whether reset really blocks stepping. Enable is held inactive, which separates holding from advancing. The stream is paused partway and then resumed, which catches a lost or repeated bit. Enable is then held until both images are exhausted, which exposes off-by-one errors at the handoff and at the end. The whole run is repeated after a second reset, and each reassembled stream is compared against the two images concatenated.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    typedef enum logic {
        RST_ACT_LOW  = 1'b0,
        RST_ACT_HIGH = 1'b1
    } rst_pol_e;

    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/scfg_addr_ctr.sv
module scfg_addr_ctr #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    output logic [AW-1:0] addr_o,
    output logic          done_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          done;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i && !st_q.done) begin
            if (st_q.addr == LAST) begin
                st_d.done = 1'b1;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign done_o = st_q.done;

    assert_hold_when_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(st_q));

    assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !st_q.done && st_q.addr != LAST) |=> (st_q.addr == AW'($past(st_q.addr) + 1'b1)));

    assert_done_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.done |=> (st_q.done && st_q.addr == LAST));

    assert_addr_in_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.addr <= LAST);
endmodule

// File: rtl/scfg_bit_rom.sv
module scfg_bit_rom #(
    parameter int               DEPTH = 64,
    parameter int               AW    = 6,
    parameter logic [DEPTH-1:0] INIT  = '0
) (
    input  logic [AW-1:0] addr_i,
    output logic          bit_o
);
    localparam int SPAN = 1 << AW;

    logic [SPAN-1:0] padded;

    for (genvar g = 0; g < SPAN; g++) begin : g_pad
        if (g < DEPTH) begin : g_used
            assign padded[g] = INIT[g];
        end else begin : g_spare
            assign padded[g] = 1'b0;
        end
    end

    assign bit_o = padded[addr_i];
endmodule

// File: rtl/scfg_out_stage.sv
module scfg_out_stage (
    input  logic en_i,
    input  logic rst_i,
    input  logic done_i,
    input  logic bit_i,
    output wire  dat_o,
    output logic dat_oe_o,
    output logic ceo_n_o
);
    assign dat_oe_o = en_i && !rst_i && !done_i;
    assign ceo_n_o  = !done_i;
    assign dat_o    = dat_oe_o ? bit_i : 1'bz;
endmodule

// File: rtl/scfg_store.sv
module scfg_store
    import scfg_pkg::*;
#(
    parameter int               DEPTH   = 64,
    parameter rst_pol_e         RST_POL = RST_ACT_HIGH,
    parameter logic [DEPTH-1:0] INIT    = '0
) (
    input  logic clk,
    input  logic ce_n,
    input  logic rst,
    output wire  dat,
    output logic dat_oe,
    output logic ceo_n
);
    localparam int AW = addr_bits(DEPTH);

    logic          rst_int;
    logic          en;
    logic [AW-1:0] addr;
    logic          done;
    logic          cur_bit;

    if (RST_POL == RST_ACT_HIGH) begin : g_rst_hi
        assign rst_int = rst;
    end else begin : g_rst_lo
        assign rst_int = !rst;
    end

    assign en = !ce_n && !rst_int;

    scfg_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
        .clk_i  (clk),
        .rst_i  (rst_int),
        .en_i   (en),
        .addr_o (addr),
        .done_o (done)
    );

    scfg_bit_rom #(.DEPTH(DEPTH), .AW(AW), .INIT(INIT)) u_rom (
        .addr_i (addr),
        .bit_o  (cur_bit)
    );

    scfg_out_stage u_out (
        .en_i     (!ce_n),
        .rst_i    (rst_int),
        .done_i   (done),
        .bit_i    (cur_bit),
        .dat_o    (dat),
        .dat_oe_o (dat_oe),
        .ceo_n_o  (ceo_n)
    );

    assert_quiet_after_end_R5: assert property (@(posedge clk) disable iff (rst_int)
        !ceo_n |-> !dat_oe);

    assert_ceo_sticky_R5: assert property (@(posedge clk) disable iff (rst_int)
        !ceo_n |=> !ceo_n);
endmodule

// File: tb/scfg_store_tb.sv
`timescale 1ns/1ps
module scfg_store_tb_top;
    import scfg_pkg::*;

    localparam int            DA = 24;
    localparam int            DB = 16;
    localparam logic [DA-1:0] IA = 24'hC3A55A;
    localparam logic [DB-1:0] IB = 16'h8E71;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic ce_n  = 1'b1;
    logic rst_a = 1'b1;
    wire  rst_b = ~rst_a;
    wire  dat_a, dat_b;
    wire  oe_a, oe_b, ceo_a_n, ceo_b_n;

    scfg_store #(.DEPTH(DA), .RST_POL(RST_ACT_HIGH), .INIT(IA)) dut_i (
        .clk(clk), .ce_n(ce_n), .rst(rst_a), .dat(dat_a), .dat_oe(oe_a), .ceo_n(ceo_a_n));

    scfg_store #(.DEPTH(DB), .RST_POL(RST_ACT_LOW), .INIT(IB)) dut_b_i (
        .clk(clk), .ce_n(ceo_a_n), .rst(rst_b), .dat(dat_b), .dat_oe(oe_b), .ceo_n(ceo_b_n));

    int  checks = 0;
    int  fails  = 0;
    int  ia = 0, ib = 0;
    bit  da = 0, db = 0;
    bit  finished = 0;
    logic got[$];

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic ce_v, input logic rst_v);
        logic eoa, eob;
        @(negedge clk);
        ce_n  = ce_v;
        rst_a = rst_v;
        #1;
        if (rst_v) begin
            ia = 0; ib = 0; da = 0; db = 0;
        end
        eoa = !ce_v && !rst_v && !da;
        eob = da && !rst_v && !db;
        cmp(tag, "oe_a", oe_a, eoa);
        cmp(tag, "oe_b", oe_b, eob);
        cmp(tag, "ceo_a_n", ceo_a_n, !da);
        cmp(tag, "ceo_b_n", ceo_b_n, !db);
        if (eoa) cmp(tag, "dat_a", dat_a, IA[ia]);
        if (eob) cmp(tag, "dat_b", dat_b, IB[ib]);
        if (oe_a) got.push_back(dat_a);
        else if (oe_b) got.push_back(dat_b);
        @(posedge clk);
        if (eoa) begin
            ia++;
            if (ia == DA) begin ia = DA - 1; da = 1; end
        end else if (eob) begin
            ib++;
            if (ib == DB) begin ib = DB - 1; db = 1; end
        end
    endtask

    task automatic check_stream(input string tag);
        cmp(tag, "stream length ok", got.size() == DA + DB, 1'b1);
        if (got.size() == DA + DB) begin
            for (int i = 0; i < DA + DB; i++) begin
                cmp(tag, $sformatf("stream bit %0d", i), got[i], (i < DA) ? IA[i] : IB[i - DA]);
            end
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        // R4: edges with reset active and enable low do not advance
        repeat (3) step("R4", 1'b0, 1'b1);
        // R1: reset state on both stores
        step("R1", 1'b1, 1'b1);
        // R3: enable inactive, nothing driven, address held
        repeat (3) step("R3", 1'b1, 1'b0);
        got.delete();
        // R2: streaming first store
        repeat (10) step("R2", 1'b0, 1'b0);
        // R8: pause then resume
        repeat (3) step("R8", 1'b1, 1'b0);
        // R5: run both images to the end and beyond
        repeat (DA + DB - 10 + 6) step("R5", 1'b0, 1'b0);
        check_stream("R6");
        // R7: second reset clears both, including the active-low store
        repeat (2) step("R7", 1'b0, 1'b1);
        got.delete();
        repeat (DA + DB + 3) step("R6", 1'b0, 1'b0);
        check_stream("R6");
        summary();
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule